// File: doc/BRIEF.md
# Single-Wire Bus ROM Search Sequencer

This block runs one pass of the device-ID search on a single-wire bus. Each pass finds exactly one 64-bit device identifier. The block does not drive the wire. It asks a bit-slot engine for three kinds of slot: reset, read and write. Each request is a level that stays up until the slot engine acknowledges it. A pass starts with a reset slot and then writes the search command byte. After that, each of the 64 bit positions takes two reads (the bit, then its complement) and one write of the chosen direction.

The branch decision is made in hardware. When the two reads show a conflict, the block uses three things to decide which way to go: the identifier and the discrepancy index from the previous pass, and the current bit position. It records the position of the last open branch, and software feeds this value back to walk the whole bus. A serial CRC-8 runs over the chosen bits as they are decided, so the verdict is ready as soon as the last bit is written. A family comparator flags identifiers whose low byte is one of four device types of interest.

Top module: `ow_rom_search`

## Requirements
- R1: While reset is held and after it is released, done_o, error_o, crc_ok_o, family_match_o and slot_req_o are 0.
- R2: A start_i pulse while idle issues one reset slot (kind 0). It is followed by eight write slots (kind 2) that carry the byte 0xF0 least significant bit first. Then, for each index 0 to 63, come a read slot (kind 1), a second read slot and a write slot: 201 slots in a successful pass.
- R3: When the two reads at an index differ, ID bit [index] is set to the first read value, and that value is the one written in the following write slot.
- R4: When both reads at an index are 1, the pass ends with no write slot for that index, and error_o=1, id_o=0, disc_o=0, crc_ok_o=0.
- R5: When both reads are 0, the chosen bit depends on how the index compares with the previous discrepancy. If they are equal, the bit is 1. If the index is greater, the bit is 0 and the index is recorded. If the index is less, the bit is the previous ID bit at that index, and the index is recorded if that bit is 0. The chosen bit is written back.
- R6: disc_o is the last index recorded during the pass, or 0 if none was recorded.
- R7: crc_ok_o is 1 when the CRC-8 of the found ID is zero. The CRC is taken bit 0 first, with reflected polynomial 0x8C and initial value 0.
- R8: family_match_o is 1 only when crc_ok_o is 1 and id_o[7:0] is 0x0B, 0x09, 0x89 or 0x91.
- R9: done_o is high for one cycle after the final slot of a pass. id_o, disc_o, error_o, crc_ok_o and family_match_o then hold until the next accepted start.
- R10: start_i is ignored during a pass, and prev_id_i and prev_disc_i are used only as sampled at the accepted start.
- R11: slot_req_o, slot_kind_o and slot_wbit_o stay unchanged until slot_ack_i. Each cycle with slot_ack_i high completes exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search pass (idle only) |
| prev_id_i | input | 64 | ID found by the previous pass |
| prev_disc_i | input | 6 | Discrepancy index from the previous pass |
| slot_req_o | output | 1 | Slot request level |
| slot_kind_o | output | 2 | 0 reset, 1 read, 2 write |
| slot_wbit_o | output | 1 | Bit for a write slot |
| slot_ack_i | input | 1 | Slot complete |
| slot_rbit_i | input | 1 | Bit sampled by a read slot, valid with ack |
| id_o | output | 64 | Found ID |
| disc_o | output | 6 | New discrepancy index |
| done_o | output | 1 | End-of-pass pulse |
| error_o | output | 1 | Search failed |
| crc_ok_o | output | 1 | ID passes CRC-8 |
| family_match_o | output | 1 | Valid ID with a family of interest |

## Verification
Two things can fall in the same cycle: a new start request and a pass already in flight. A start pulse is injected in the middle of a pass, while the previous-ID inputs are changed at the same moment. The bench then judges the outcome in three ways: exactly one reset slot must appear, the slot count must not change, and the result must match the reference computed from the inputs that were sampled. In a second case, the verdict logic has to settle the CRC result and the family match in the same cycle as the last write acknowledgement. Bus models with matching families, with other families, with a corrupted check byte and with no devices at all show whether the verdict follows the accumulated CRC.

// File: rtl/ows_pkg.sv
package ows_pkg;
  typedef enum logic [1:0] {
    SLOT_RESET = 2'd0,
    SLOT_READ  = 2'd1,
    SLOT_WRITE = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_CMD,
    S_RDA,
    S_RDB,
    S_WR,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/ows_branch.sv
module ows_branch #(
  parameter int IDX_W = 6
) (
  input  logic             bit_a_i,
  input  logic             bit_b_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             prev_bit_i,
  output logic             fail_o,
  output logic             pick_o,
  output logic             mark_o
);
  always_comb begin
    fail_o = bit_a_i & bit_b_i;
    pick_o = bit_a_i;
    mark_o = 1'b0;
    if (!bit_a_i && !bit_b_i) begin
      if (idx_i == last_i) begin
        pick_o = 1'b1;
      end else if (idx_i > last_i) begin
        pick_o = 1'b0;
        mark_o = 1'b1;
      end else begin
        pick_o = prev_bit_i;
        mark_o = ~prev_bit_i;
      end
    end
  end
endmodule

// File: rtl/ows_crc8.sv
module ows_crc8 #(
  parameter int          CRC_W    = 8,
  parameter logic [7:0]  CRC_POLY = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    crc_d = crc_q;
    fb    = crc_q[0] ^ din_i;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = crc_q >> 1;
      if (fb) crc_d = crc_d ^ CRC_POLY[CRC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (clr_i || en_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ows_family.sv
module ows_family #(
  parameter int               FAM_W = 8,
  parameter int               FAM_N = 4,
  parameter logic [FAM_W*FAM_N-1:0] CODES = 32'h91_89_09_0B
) (
  input  logic [FAM_W-1:0] fam_i,
  output logic             hit_o
);
  logic [FAM_N-1:0] match;

  for (genvar g = 0; g < FAM_N; g++) begin : g_cmp
    assign match[g] = (fam_i == CODES[g*FAM_W +: FAM_W]);
  end

  assign hit_o = |match;
endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search #(
  parameter int          ID_BITS   = 64,
  parameter int          CMD_BITS  = 8,
  parameter logic [7:0]  CMD_CODE  = 8'hF0,
  parameter int          CRC_W     = 8,
  parameter logic [7:0]  CRC_POLY  = 8'h8C,
  parameter int          FAM_W     = 8,
  parameter int          FAM_N     = 4,
  parameter logic [31:0] FAM_CODES = 32'h91_89_09_0B
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [ID_BITS-1:0]         prev_id_i,
  input  logic [$clog2(ID_BITS)-1:0] prev_disc_i,
  output logic                       slot_req_o,
  output logic [1:0]                 slot_kind_o,
  output logic                       slot_wbit_o,
  input  logic                       slot_ack_i,
  input  logic                       slot_rbit_i,
  output logic [ID_BITS-1:0]         id_o,
  output logic [$clog2(ID_BITS)-1:0] disc_o,
  output logic                       done_o,
  output logic                       error_o,
  output logic                       crc_ok_o,
  output logic                       family_match_o
);
  import ows_pkg::*;

  localparam int IDX_W = $clog2(ID_BITS);
  localparam int CNT_W = $clog2(CMD_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cmd_cnt_q, cmd_cnt_d;
  logic [ID_BITS-1:0] id_q, id_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W-1:0] disc_q, disc_d;
  logic             a_q, a_d;
  logic             wbit_q, wbit_d;
  logic             err_q, err_d;
  logic             crc_ok_q, crc_ok_d;
  logic             fam_q, fam_d;

  logic             crc_clr, crc_en;
  logic [CRC_W-1:0] crc_val;
  logic             br_fail, br_pick, br_mark;
  logic             fam_hit;
  logic             crc_zero;

  ows_branch #(.IDX_W(IDX_W)) u_branch (
    .bit_a_i   (a_q),
    .bit_b_i   (slot_rbit_i),
    .idx_i     (idx_q),
    .last_i    (last_q),
    .prev_bit_i(id_q[idx_q]),
    .fail_o    (br_fail),
    .pick_o    (br_pick),
    .mark_o    (br_mark)
  );

  ows_crc8 #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .din_i (br_pick),
    .crc_o (crc_val)
  );

  ows_family #(.FAM_W(FAM_W), .FAM_N(FAM_N), .CODES(FAM_CODES[FAM_W*FAM_N-1:0])) u_family (
    .fam_i (id_q[FAM_W-1:0]),
    .hit_o (fam_hit)
  );

  assign crc_zero = (crc_val == '0);

  // next-state process
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cmd_cnt_d = cmd_cnt_q;
    id_d      = id_q;
    last_d    = last_q;
    disc_d    = disc_q;
    a_d       = a_q;
    wbit_d    = wbit_q;
    err_d     = err_q;
    crc_ok_d  = crc_ok_q;
    fam_d     = fam_q;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d   = S_RST;
          id_d      = prev_id_i;
          last_d    = prev_disc_i;
          disc_d    = '0;
          idx_d     = '0;
          cmd_cnt_d = '0;
          err_d     = 1'b0;
          crc_ok_d  = 1'b0;
          fam_d     = 1'b0;
          crc_clr   = 1'b1;
        end
      end
      S_RST: begin
        if (slot_ack_i) state_d = S_CMD;
      end
      S_CMD: begin
        if (slot_ack_i) begin
          if (cmd_cnt_q == LAST_CMD) state_d = S_RDA;
          else cmd_cnt_d = cmd_cnt_q + 1'b1;
        end
      end
      S_RDA: begin
        if (slot_ack_i) begin
          a_d     = slot_rbit_i;
          state_d = S_RDB;
        end
      end
      S_RDB: begin
        if (slot_ack_i) begin
          if (br_fail) begin
            id_d    = '0;
            disc_d  = '0;
            err_d   = 1'b1;
            state_d = S_FIN;
          end else begin
            id_d[idx_q] = br_pick;
            wbit_d      = br_pick;
            crc_en      = 1'b1;
            if (br_mark) disc_d = idx_q;
            state_d = S_WR;
          end
        end
      end
      S_WR: begin
        if (slot_ack_i) begin
          if (idx_q == LAST_IDX) begin
            crc_ok_d = crc_zero;
            fam_d    = crc_zero & fam_hit;
            state_d  = S_FIN;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_RDA;
          end
        end
      end
      S_FIN: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      cmd_cnt_q <= '0;
      id_q      <= '0;
      last_q    <= '0;
      disc_q    <= '0;
      a_q       <= 1'b0;
      wbit_q    <= 1'b0;
      err_q     <= 1'b0;
      crc_ok_q  <= 1'b0;
      fam_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      cmd_cnt_q <= cmd_cnt_d;
      id_q      <= id_d;
      last_q    <= last_d;
      disc_q    <= disc_d;
      a_q       <= a_d;
      wbit_q    <= wbit_d;
      err_q     <= err_d;
      crc_ok_q  <= crc_ok_d;
      fam_q     <= fam_d;
    end
  end

  // slot interface
  always_comb begin
    slot_req_o  = 1'b0;
    slot_kind_o = SLOT_RESET;
    slot_wbit_o = 1'b0;
    unique case (state_q)
      S_RST: slot_req_o = 1'b1;
      S_CMD: begin
        slot_req_o  = 1'b1;
        slot_kind_o = SLOT_WRITE;
        slot_wbit_o = CMD_CODE[cmd_cnt_q];
      end
      S_RDA, S_RDB: begin
        slot_req_o  = 1'b1;
        slot_kind_o = SLOT_READ;
      end
      S_WR: begin
        slot_req_o  = 1'b1;
        slot_kind_o = SLOT_WRITE;
        slot_wbit_o = wbit_q;
      end
      default: ;
    endcase
  end

  assign id_o           = id_q;
  assign disc_o         = disc_q;
  assign done_o         = (state_q == S_FIN);
  assign error_o        = err_q;
  assign crc_ok_o       = crc_ok_q;
  assign family_match_o = fam_q;

  // checks next to the logic they guard
  p_wbit_is_id_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_WR) |-> (slot_wbit_o == id_q[idx_q]));

  p_fail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && error_o) |-> (id_o == '0 && disc_o == '0 && !crc_ok_o));

  p_family_valid_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    family_match_o |-> crc_ok_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  p_slot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_kind_o) && $stable(slot_wbit_o)));

  p_ack_in_slot_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    slot_ack_i |-> slot_req_o);
endmodule

// File: tb/test_ow_rom_search.sv
module test_ow_rom_search;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [63:0] prev_id_i;
  logic [5:0]  prev_disc_i;
  logic        slot_req_o;
  logic [1:0]  slot_kind_o;
  logic        slot_wbit_o;
  logic        slot_ack_i;
  logic        slot_rbit_i;
  logic [63:0] id_o;
  logic [5:0]  disc_o;
  logic        done_o, error_o, crc_ok_o, family_match_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_rom_search i_ow_rom_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prev_id_i(prev_id_i),
    .prev_disc_i(prev_disc_i), .slot_req_o(slot_req_o), .slot_kind_o(slot_kind_o),
    .slot_wbit_o(slot_wbit_o), .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i),
    .id_o(id_o), .disc_o(disc_o), .done_o(done_o), .error_o(error_o),
    .crc_ok_o(crc_ok_o), .family_match_o(family_match_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ v[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
    logic [63:0] v = {8'h00, ser, fam};
    v[63:56] = crc8(v, 56);
    return v;
  endfunction

  // bus model: devices answer read slots wired-AND
  logic [63:0] dev [8];
  int          dev_n;
  logic [7:0]  active;
  int          lat, lat_cnt;
  int          rd_phase, cmd_bits, sidx;
  logic [7:0]  cmd_sh;
  int          slots, resets;
  bit          hs_viol;
  logic        p_req, p_ack;
  logic [1:0]  p_kind;

  function automatic logic bus_bit(input logic [7:0] act, input int idx, input bit inv);
    logic r = 1'b1;
    for (int d = 0; d < dev_n; d++)
      if (act[d]) r = r & (inv ? ~dev[d][idx] : dev[d][idx]);
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      slot_ack_i = 1'b0; slot_rbit_i = 1'b0; lat_cnt = 0;
      p_req = 1'b0; p_ack = 1'b0; p_kind = 2'd0;
    end else begin
      if (p_req && !p_ack && (!slot_req_o || slot_kind_o != p_kind)) hs_viol = 1'b1;
      if (slot_ack_i) begin
        slot_ack_i = 1'b0;
      end else if (slot_req_o) begin
        if (lat_cnt < lat) lat_cnt++;
        else begin
          lat_cnt = 0;
          slot_ack_i = 1'b1;
          slots++;
          case (slot_kind_o)
            2'd0: begin
              resets++; active = 8'hFF; rd_phase = 0; cmd_bits = 0; sidx = 0;
            end
            2'd1: begin
              slot_rbit_i = bus_bit(active, sidx, rd_phase != 0);
              rd_phase ^= 1;
            end
            default: begin
              if (cmd_bits < 8) begin
                cmd_sh[cmd_bits] = slot_wbit_o; cmd_bits++;
              end else begin
                for (int d = 0; d < 8; d++)
                  if (d < dev_n && dev[d][sidx] != slot_wbit_o) active[d] = 1'b0;
                sidx++; rd_phase = 0;
              end
            end
          endcase
        end
      end
      p_req = slot_req_o; p_kind = slot_kind_o; p_ack = slot_ack_i;
    end
  end

  // reference of the search rules (R3..R6)
  task automatic ref_search(input logic [63:0] pid, input logic [5:0] pdisc,
                            output logic [63:0] rid, output logic [5:0] rdisc,
                            output bit rerr, output int fidx);
    logic [7:0] act = 8'hFF;
    rid = pid; rdisc = 6'd0; rerr = 1'b0; fidx = 64;
    for (int i = 0; i < 64; i++) begin
      logic a = bus_bit(act, i, 1'b0);
      logic b = bus_bit(act, i, 1'b1);
      logic c;
      if (a && b) begin
        rid = '0; rdisc = '0; rerr = 1'b1; fidx = i;
        return;
      end
      if (a != b) c = a;
      else if (i == int'(pdisc)) c = 1'b1;
      else if (i > int'(pdisc)) begin c = 1'b0; rdisc = 6'(i); end
      else begin c = pid[i]; if (!c) rdisc = 6'(i); end
      rid[i] = c;
      for (int d = 0; d < 8; d++)
        if (d < dev_n && dev[d][i] != c) act[d] = 1'b0;
    end
  endtask

  logic [63:0] last_id;
  logic [5:0]  last_disc;

  task automatic run(input int lat_v, input logic [63:0] pid, input logic [5:0] pdisc, input bit poke);
    logic [63:0] eid; logic [5:0] edisc; bit eerr; int fidx; int w;
    bit ecrc, efam;
    ref_search(pid, pdisc, eid, edisc, eerr, fidx);
    lat = lat_v; slots = 0; resets = 0; hs_viol = 1'b0; cmd_sh = 8'h00;
    @(negedge clk);
    prev_id_i = pid; prev_disc_i = pdisc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      // R10: start and changed inputs during a pass
      prev_id_i = ~pid; prev_disc_i = pdisc + 6'd7; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 5000) begin @(negedge clk); w++; end
    chk(done_o, "R9 done", 64'(done_o), 64'd1);
    ecrc = !eerr && (crc8(eid, 64) == 8'h00);
    efam = ecrc && (eid[7:0] inside {8'h0B, 8'h09, 8'h89, 8'h91});
    chk(id_o == eid, eerr ? "R4 id" : "R3/R5 id", id_o, eid);
    chk(disc_o == edisc, "R6 disc", 64'(disc_o), 64'(edisc));
    chk(error_o == eerr, "R4 error", 64'(error_o), 64'(eerr));
    chk(crc_ok_o == ecrc, "R7 crc_ok", 64'(crc_ok_o), 64'(ecrc));
    chk(family_match_o == efam, "R8 family", 64'(family_match_o), 64'(efam));
    chk(cmd_sh == 8'hF0, "R2 command", 64'(cmd_sh), 64'hF0);
    chk(resets == 1, "R2/R10 reset slots", 64'(resets), 64'd1);
    chk(slots == (eerr ? 11 + 3*fidx : 201), "R2 slot count", 64'(slots),
        64'(eerr ? 11 + 3*fidx : 201));
    chk(!hs_viol, "R11 handshake", 64'(hs_viol), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk(!done_o && id_o == eid && disc_o == edisc && error_o == eerr && crc_ok_o == ecrc,
        "R9 hold", id_o, eid);
    last_id = eid; last_disc = edisc;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; prev_id_i = '0; prev_disc_i = '0;
    slot_ack_i = 1'b0; slot_rbit_i = 1'b0; dev_n = 0; lat = 0; active = 8'hFF;
    repeat (3) @(negedge clk);
    chk(!done_o && !error_o && !crc_ok_o && !family_match_o && !slot_req_o,
        "R1 in reset", {59'd0, done_o, error_o, crc_ok_o, family_match_o, slot_req_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done_o && !error_o && !crc_ok_o && !family_match_o && !slot_req_o,
        "R1 after reset", {59'd0, done_o, error_o, crc_ok_o, family_match_o, slot_req_o}, 64'd0);

    for (int s = 0; s < 5; s++) begin
      case (s)
        0: begin dev_n = 1; dev[0] = make_id(8'h28, 48'h0000_1234_5678); end
        1: begin dev_n = 2; dev[0] = make_id(8'h0B, 48'hA5); dev[1] = make_id(8'h09, 48'hA4); end
        2: begin
          dev_n = 4;
          dev[0] = make_id(8'h89, 48'h1); dev[1] = make_id(8'h91, 48'h1);
          dev[2] = make_id(8'h10, 48'h3); dev[3] = make_id(8'h0B, 48'h2);
        end
        3: begin dev_n = 1; dev[0] = make_id(8'h09, 48'h77) ^ (64'h1 << 60); end
        default: dev_n = 0;
      endcase
      last_id = '0; last_disc = '0;
      for (int r = 0; r <= dev_n; r++)
        run((s + r) % 3, last_id, last_disc, (s == 2 && r == 1));
    end

    // R5: explicit discrepancy starting points on the four-device bus
    dev_n = 4;
    dev[0] = make_id(8'h89, 48'h1); dev[1] = make_id(8'h91, 48'h1);
    dev[2] = make_id(8'h10, 48'h3); dev[3] = make_id(8'h0B, 48'h2);
    for (int k = 0; k < 4; k++)
      run(k % 2, dev[k], 6'((k * 19 + 3) % 64), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule